// File: doc/BRIEF.md
# USB Device Interrupt Hierarchy

This block collects every interrupt condition of a USB device controller and folds it down to one interrupt line. It works in three levels. At the bottom, single events set bits in four device group status registers and in one OTG status register. Each status bit has a mask bit beside it. In the middle, a summary register shows which device groups hold a pending bit that is not masked. At the top, a global stage merges three sources into one registered line: the device summary after a per-group gate, the OTG register after its enable register, and a host level. The polarity of that line is programmable.

Status bits come in two kinds. Sticky bits are set by a one-cycle input pulse and stay set until software writes a one to them. Live bits copy an input level and ignore writes. Software reaches all registers through a simple word-addressed port. Writes take effect on the clock edge. Read data is combinational from the current state.

Register addresses on `bus_addr`:
- 0 / 1: control-endpoint status / mask
- 2 / 3: FIFO status / mask
- 4 / 5: bus-event status / mask
- 6 / 7: auxiliary status / mask
- 8: group summary
- 9: group gate
- 10 / 11: OTG status / enable
- 12: global status
- 13: global control

Top module: `usb_irq_hub`

## Requirements
- R1: Control-endpoint group (address 0). Bits 0 to 4 follow `cx_live[4:0]`: setup, IN, OUT, status-stage end and failure. Bit 5 (abort) is sticky. It is set by `cx_abort` and cleared by writing 1 to it.
- R2: FIFO group (address 2) is entirely live. For FIFO n, bit 2n follows `fifo_out_live[n]`, bit 2n+1 follows `fifo_short_live[n]` and bit 16+n follows `fifo_in_live[n]`. Every other bit reads 0.
- R3: Bus-event group (address 4). Bits 0 to 8 are sticky: bit k is set by `bus_evt[k]` and cleared by writing 1 to it. Bit 9 follows `idle_live` and bit 10 follows `vbus_wake_live`.
- R4: Auxiliary group (address 6). Bits 0 to 3 are sticky. Bit k is set by `aux_evt[k]` and cleared by writing 1 to it.
- R5: Writes have no effect on live status bits. Writing 0 to a sticky bit leaves it unchanged. Writes to the summary (8) and global status (12) registers have no effect.
- R6: If a set pulse and a write of 1 to the same sticky bit fall in the same cycle, the bit ends up set.
- R7: A mask bit at 1 disables its status bit. Summary bit g (address 8) is 1 exactly when group g has a status bit at 1 whose mask bit is 0.
- R8: Bit g of the group gate (address 9) at 1 removes group g from the device source. The summary register still shows group g.
- R9: The OTG status register (address 10) holds 13 sticky bits. Bit k is set by `otg_evt[k]` and cleared by writing 1 to it; bit 6 is session end. The OTG source is active when any status bit is 1 and the matching bit of the enable register (address 11) is 1. An enable of 0 blocks the OTG source.
- R10: Global status (address 12) shows the device source in bit 0, the OTG source in bit 1 and `host_live` in bit 2. Global control (address 13) bits 0 to 2 mask these three sources when at 1. Bit 3 sets the polarity: 1 means `irq_o` is high when active, 0 means low when active.
- R11: `irq_o` is registered. It reflects the status, mask, gate, enable and control state of the previous cycle.
- R12: After reset:
  - all status, mask, gate, enable and control registers are 0;
  - `irq_o` is 1, the inactive level for the default active-low polarity.
- R13: Reads of addresses 14 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cx_live | input | 5 | Control-endpoint live conditions |
| cx_abort | input | 1 | Control-endpoint abort pulse |
| fifo_out_live | input | 4 | Per-FIFO OUT-data level |
| fifo_short_live | input | 4 | Per-FIFO short-packet level |
| fifo_in_live | input | 4 | Per-FIFO IN-ready level |
| bus_evt | input | 9 | Bus and DMA event pulses |
| idle_live | input | 1 | Device idle level |
| vbus_wake_live | input | 1 | Wake-by-VBUS level |
| aux_evt | input | 4 | Auxiliary event pulses |
| otg_evt | input | 13 | OTG event pulses |
| host_live | input | 1 | Host interrupt level |
| irq_o | output | 1 | Merged interrupt line |

## Verification
The assertions assume that reset is driven asynchronously and held across at least one clock edge. They also assume that all inputs are stable around the rising edge. The bench therefore changes every input at the falling edge and keeps them at 0 during reset. Event inputs are treated as one-cycle pulses. The random stimulus makes them sparse, so that sticky bits are seen both while set and after being cleared. Writes are spread over the whole address space, including the read-only and unmapped addresses, so that the hold and ignore properties are also exercised.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int DW      = 32;
    localparam int AW      = 4;
    localparam int NFIFO   = 4;
    localparam int NGRP    = 4;
    localparam int NSRC    = 3;
    localparam int CX_W    = 6;
    localparam int G1_W    = 16 + NFIFO;
    localparam int G2_W    = 11;
    localparam int AUX_W   = 4;
    localparam int OTG_W   = 13;
    localparam int BEVT_W  = 9;

    localparam logic [CX_W-1:0]  CX_STICKY  = 6'b10_0000;
    localparam logic [G2_W-1:0]  G2_STICKY  = 11'h1FF;

    localparam logic [AW-1:0] A_CX_STS  = 4'd0;
    localparam logic [AW-1:0] A_CX_MSK  = 4'd1;
    localparam logic [AW-1:0] A_FF_STS  = 4'd2;
    localparam logic [AW-1:0] A_FF_MSK  = 4'd3;
    localparam logic [AW-1:0] A_BE_STS  = 4'd4;
    localparam logic [AW-1:0] A_BE_MSK  = 4'd5;
    localparam logic [AW-1:0] A_AX_STS  = 4'd6;
    localparam logic [AW-1:0] A_AX_MSK  = 4'd7;
    localparam logic [AW-1:0] A_SUMMARY = 4'd8;
    localparam logic [AW-1:0] A_GATE    = 4'd9;
    localparam logic [AW-1:0] A_OTG_STS = 4'd10;
    localparam logic [AW-1:0] A_OTG_EN  = 4'd11;
    localparam logic [AW-1:0] A_GSTS    = 4'd12;
    localparam logic [AW-1:0] A_GCTL    = 4'd13;
endpackage

// File: rtl/usb_irq_group.sv
module usb_irq_group #(
    parameter int            W         = 8,
    parameter logic [W-1:0]  STICKY    = '0,
    parameter bit            MSK_IS_EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] live_i,
    input  logic         sts_wr_i,
    input  logic         msk_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] sts_o,
    output logic [W-1:0] msk_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] sts;
        logic [W-1:0] msk;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sts_wr_i) begin
            st_d.sts = st_q.sts & ~wdata_i;
        end
        st_d.sts = (st_d.sts | set_i) & STICKY;
        if (msk_wr_i) begin
            st_d.msk = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = (st_q.sts & STICKY) | (live_i & ~STICKY);
    assign msk_o = st_q.msk;

    generate
        if (MSK_IS_EN) begin : g_enable
            assign pend_o = |(sts_o & st_q.msk);
        end else begin : g_disable
            assign pend_o = |(sts_o & ~st_q.msk);
        end
    endgenerate

    // R6: a pulse always leaves its bit set, whatever the write did
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & STICKY)) |=>
        ((st_q.sts & $past(set_i & STICKY)) == $past(set_i & STICKY)));

    // R5: without a status write no sticky bit falls
    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_wr_i) |=> (($past(st_q.sts) & ~st_q.sts) == '0));

    // R7: mask only changes on its own write
    p_mask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!msk_wr_i) |=> $stable(st_q.msk));
endmodule

// File: rtl/usb_irq_merge.sv
module usb_irq_merge #(
    parameter int NG = 4,
    parameter int NS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] grp_pend_i,
    input  logic          otg_pend_i,
    input  logic          host_i,
    input  logic          gate_wr_i,
    input  logic          ctl_wr_i,
    input  logic [NG-1:0] gate_wdata_i,
    input  logic [NS:0]   ctl_wdata_i,
    output logic [NG-1:0] summary_o,
    output logic [NG-1:0] gate_o,
    output logic [NS-1:0] gsts_o,
    output logic [NS:0]   ctl_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [NG-1:0] gate;
        logic [NS:0]   ctl;
        logic          irq;
    } mrg_st_t;

    mrg_st_t st_d, st_q;
    logic    dev_src;
    logic    active;

    assign summary_o = grp_pend_i;
    assign dev_src   = |(grp_pend_i & ~st_q.gate);
    assign gsts_o    = {host_i, otg_pend_i, dev_src};
    assign active    = |(gsts_o & ~st_q.ctl[NS-1:0]);

    always_comb begin
        st_d = st_q;
        if (gate_wr_i) st_d.gate = gate_wdata_i;
        if (ctl_wr_i)  st_d.ctl  = ctl_wdata_i;
        st_d.irq = st_q.ctl[NS] ? active : ~active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{gate: '0, ctl: '0, irq: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;
    assign ctl_o  = st_q.ctl;
    assign irq_o  = st_q.irq;

    // R10: control register holds between its writes
    p_ctl_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_i) |=> $stable(st_q.ctl));

    // R11: with every contributor frozen, the line is frozen one cycle on
    p_irq_registered_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(grp_pend_i) && $stable(otg_pend_i) &&
         $stable(host_i) && $stable(st_q.gate) && $stable(st_q.ctl))
        |=> $stable(irq_o));
endmodule

// File: rtl/usb_irq_hub.sv
module usb_irq_hub
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [CX_W-2:0]   cx_live,
    input  logic              cx_abort,
    input  logic [NFIFO-1:0]  fifo_out_live,
    input  logic [NFIFO-1:0]  fifo_short_live,
    input  logic [NFIFO-1:0]  fifo_in_live,
    input  logic [BEVT_W-1:0] bus_evt,
    input  logic              idle_live,
    input  logic              vbus_wake_live,
    input  logic [AUX_W-1:0]  aux_evt,
    input  logic [OTG_W-1:0]  otg_evt,
    input  logic              host_live,
    output logic              irq_o
);
    logic [CX_W-1:0]  cx_sts, cx_msk;
    logic [G1_W-1:0]  ff_sts, ff_msk, ff_live;
    logic [G2_W-1:0]  be_sts, be_msk;
    logic [AUX_W-1:0] ax_sts, ax_msk;
    logic [OTG_W-1:0] otg_sts, otg_en;
    logic [NGRP-1:0]  grp_pend, summary, gate;
    logic [NSRC-1:0]  gsts;
    logic [NSRC:0]    gctl;
    logic             otg_pend;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[DW-1:G1_W];

    function automatic logic hit(input logic [AW-1:0] a);
        return bus_we && (bus_addr == a);
    endfunction

    always_comb begin
        ff_live = '0;
        for (int n = 0; n < NFIFO; n++) begin
            ff_live[2*n]    = fifo_out_live[n];
            ff_live[2*n+1]  = fifo_short_live[n];
            ff_live[16+n]   = fifo_in_live[n];
        end
    end

    usb_irq_group #(.W(CX_W), .STICKY(CX_STICKY), .MSK_IS_EN(1'b0)) u_cx (
        .clk(clk), .rst_n(rst_n),
        .set_i({cx_abort, {(CX_W-1){1'b0}}}), .live_i({1'b0, cx_live}),
        .sts_wr_i(hit(A_CX_STS)), .msk_wr_i(hit(A_CX_MSK)),
        .wdata_i(bus_wdata[CX_W-1:0]),
        .sts_o(cx_sts), .msk_o(cx_msk), .pend_o(grp_pend[0]));

    usb_irq_group #(.W(G1_W), .STICKY('0), .MSK_IS_EN(1'b0)) u_ff (
        .clk(clk), .rst_n(rst_n),
        .set_i('0), .live_i(ff_live),
        .sts_wr_i(hit(A_FF_STS)), .msk_wr_i(hit(A_FF_MSK)),
        .wdata_i(bus_wdata[G1_W-1:0]),
        .sts_o(ff_sts), .msk_o(ff_msk), .pend_o(grp_pend[1]));

    usb_irq_group #(.W(G2_W), .STICKY(G2_STICKY), .MSK_IS_EN(1'b0)) u_be (
        .clk(clk), .rst_n(rst_n),
        .set_i({2'b00, bus_evt}),
        .live_i({vbus_wake_live, idle_live, {BEVT_W{1'b0}}}),
        .sts_wr_i(hit(A_BE_STS)), .msk_wr_i(hit(A_BE_MSK)),
        .wdata_i(bus_wdata[G2_W-1:0]),
        .sts_o(be_sts), .msk_o(be_msk), .pend_o(grp_pend[2]));

    usb_irq_group #(.W(AUX_W), .STICKY({AUX_W{1'b1}}), .MSK_IS_EN(1'b0)) u_ax (
        .clk(clk), .rst_n(rst_n),
        .set_i(aux_evt), .live_i('0),
        .sts_wr_i(hit(A_AX_STS)), .msk_wr_i(hit(A_AX_MSK)),
        .wdata_i(bus_wdata[AUX_W-1:0]),
        .sts_o(ax_sts), .msk_o(ax_msk), .pend_o(grp_pend[3]));

    usb_irq_group #(.W(OTG_W), .STICKY({OTG_W{1'b1}}), .MSK_IS_EN(1'b1)) u_otg (
        .clk(clk), .rst_n(rst_n),
        .set_i(otg_evt), .live_i('0),
        .sts_wr_i(hit(A_OTG_STS)), .msk_wr_i(hit(A_OTG_EN)),
        .wdata_i(bus_wdata[OTG_W-1:0]),
        .sts_o(otg_sts), .msk_o(otg_en), .pend_o(otg_pend));

    usb_irq_merge #(.NG(NGRP), .NS(NSRC)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .grp_pend_i(grp_pend), .otg_pend_i(otg_pend), .host_i(host_live),
        .gate_wr_i(hit(A_GATE)), .ctl_wr_i(hit(A_GCTL)),
        .gate_wdata_i(bus_wdata[NGRP-1:0]), .ctl_wdata_i(bus_wdata[NSRC:0]),
        .summary_o(summary), .gate_o(gate), .gsts_o(gsts), .ctl_o(gctl),
        .irq_o(irq_o));

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CX_STS:  bus_rdata[CX_W-1:0]  = cx_sts;
            A_CX_MSK:  bus_rdata[CX_W-1:0]  = cx_msk;
            A_FF_STS:  bus_rdata[G1_W-1:0]  = ff_sts;
            A_FF_MSK:  bus_rdata[G1_W-1:0]  = ff_msk;
            A_BE_STS:  bus_rdata[G2_W-1:0]  = be_sts;
            A_BE_MSK:  bus_rdata[G2_W-1:0]  = be_msk;
            A_AX_STS:  bus_rdata[AUX_W-1:0] = ax_sts;
            A_AX_MSK:  bus_rdata[AUX_W-1:0] = ax_msk;
            A_SUMMARY: bus_rdata[NGRP-1:0]  = summary;
            A_GATE:    bus_rdata[NGRP-1:0]  = gate;
            A_OTG_STS: bus_rdata[OTG_W-1:0] = otg_sts;
            A_OTG_EN:  bus_rdata[OTG_W-1:0] = otg_en;
            A_GSTS:    bus_rdata[NSRC-1:0]  = gsts;
            A_GCTL:    bus_rdata[NSRC:0]    = gctl;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/test_usb_irq_hub.sv
module test_usb_irq_hub;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  cx_live = '0;
    logic        cx_abort = 1'b0;
    logic [3:0]  fifo_out_live = '0, fifo_short_live = '0, fifo_in_live = '0;
    logic [8:0]  bus_evt = '0;
    logic        idle_live = 1'b0, vbus_wake_live = 1'b0;
    logic [3:0]  aux_evt = '0;
    logic [12:0] otg_evt = '0;
    logic        host_live = 1'b0;
    logic        irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_irq_hub i_usb_irq_hub (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cx_live(cx_live),
        .cx_abort(cx_abort), .fifo_out_live(fifo_out_live),
        .fifo_short_live(fifo_short_live), .fifo_in_live(fifo_in_live),
        .bus_evt(bus_evt), .idle_live(idle_live), .vbus_wake_live(vbus_wake_live),
        .aux_evt(aux_evt), .otg_evt(otg_evt), .host_live(host_live), .irq_o(irq_o));

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] WM [4] = '{32'h3F, 32'hFFFFF, 32'h7FF, 32'hF};
    localparam logic [31:0] ST [4] = '{32'h20, 32'h0, 32'h1FF, 32'hF};

    logic [31:0] m_sts [4];
    logic [31:0] m_msk [4];
    logic [3:0]  m_gate;
    logic [12:0] m_otg, m_oen;
    logic [3:0]  m_gctl;
    logic        m_irq;

    function automatic logic [31:0] live_of(int g);
        logic [31:0] v = '0;
        case (g)
            0: v = {27'b0, cx_live};
            1: for (int n = 0; n < 4; n++) begin
                   v[2*n] = fifo_out_live[n];
                   v[2*n+1] = fifo_short_live[n];
                   v[16+n] = fifo_in_live[n];
               end
            2: v = {21'b0, vbus_wake_live, idle_live, 9'b0};
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [31:0] sts_of(int g);
        return ((m_sts[g] & ST[g]) | (live_of(g) & ~ST[g])) & WM[g];
    endfunction

    function automatic logic [3:0] summ();
        logic [3:0] s;
        for (int g = 0; g < 4; g++) s[g] = |(sts_of(g) & ~m_msk[g] & WM[g]);
        return s;
    endfunction

    function automatic logic [2:0] gsts();
        return {host_live, |(m_otg & m_oen), |(summ() & ~m_gate)};
    endfunction

    function automatic logic irq_calc();
        logic act = |(gsts() & ~m_gctl[2:0]);
        return m_gctl[3] ? act : !act;
    endfunction

    function automatic logic [31:0] read_of(logic [3:0] a);
        case (a)
            0, 2, 4, 6: return sts_of(int'(a) / 2);
            1, 3, 5, 7: return m_msk[int'(a) / 2];
            8:  return {28'b0, summ()};
            9:  return {28'b0, m_gate};
            10: return {19'b0, m_otg};
            11: return {19'b0, m_oen};
            12: return {29'b0, gsts()};
            13: return {28'b0, m_gctl};
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] a);
        case (a)
            0: return "R1";
            2: return "R2";
            4: return "R3";
            6: return "R4";
            1, 3, 5, 7, 8: return "R7";
            9: return "R8";
            10, 11: return "R9";
            12, 13: return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic model_reset();
        for (int g = 0; g < 4; g++) begin m_sts[g] = '0; m_msk[g] = '0; end
        m_gate = '0; m_otg = '0; m_oen = '0; m_gctl = '0; m_irq = 1'b1;
    endtask

    task automatic model_step();
        m_irq = irq_calc();
        if (bus_we) begin
            case (bus_addr)
                0, 2, 4, 6: m_sts[bus_addr/2] = m_sts[bus_addr/2] & ~bus_wdata;
                1, 3, 5, 7: m_msk[bus_addr/2] = bus_wdata & WM[bus_addr/2];
                9:  m_gate = bus_wdata[3:0];
                10: m_otg = m_otg & ~bus_wdata[12:0];
                11: m_oen = bus_wdata[12:0];
                13: m_gctl = bus_wdata[3:0];
                default: ;
            endcase
        end
        m_sts[0] = m_sts[0] | {26'b0, cx_abort, 5'b0};
        m_sts[2] = m_sts[2] | {23'b0, bus_evt};
        m_sts[3] = m_sts[3] | {28'b0, aux_evt};
        m_otg    = m_otg | otg_evt;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R11 irq line", {31'b0, irq_o}, {31'b0, m_irq});
        chk(req_of(bus_addr), bus_rdata, read_of(bus_addr));
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a);
        bus_addr = a;
        cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset contents, R13 on unmapped words
        chk("R12 irq idle", {31'b0, irq_o}, 32'h1);
        for (int a = 0; a < 16; a++) begin
            bus_addr = 4'(a);
            #1;
            chk(a >= 14 ? "R13" : "R12", bus_rdata, 32'h0);
        end
        cyc();

        wr(13, 32'h8);                        // active high, nothing masked
        // R6: set and write-one-clear on the same bit together
        bus_evt = 9'h001;
        wr(4, 32'h1);
        bus_evt = '0;
        chk("R6 set beats clear", {31'b0, bus_rdata[0]}, 32'h1);
        rd(4);
        chk("R11 irq after pending", {31'b0, irq_o}, 32'h1);
        // R8: gate group 2
        wr(9, 32'h4);
        rd(8);
        chk("R8 gated line", {31'b0, irq_o}, 32'h0);
        chk("R8 summary kept", bus_rdata, 32'h4);
        // R7: bit mask
        wr(9, 32'h0);
        wr(5, 32'h1);
        rd(8);
        chk("R7 masked summary", bus_rdata, 32'h0);
        chk("R7 masked line", {31'b0, irq_o}, 32'h0);
        wr(5, 32'h0);
        wr(4, 32'h1);
        rd(4);
        chk("R3 cleared", bus_rdata, 32'h0);
        // R5: writes to live bits and zero writes to sticky bits
        wr(2, 32'hFFFF_FFFF);
        rd(2);
        chk("R5 live untouched", bus_rdata, 32'h0);
        cx_abort = 1'b1;
        cyc();
        cx_abort = 1'b0;
        wr(0, 32'h0);
        rd(0);
        chk("R5 zero write keeps", bus_rdata, 32'h20);
        wr(0, 32'h20);
        wr(12, 32'hF);
        wr(8, 32'hF);
        // R1 / R2 live layout
        cx_live = 5'h15;
        rd(0);
        chk("R1 live bits", bus_rdata, 32'h15);
        cx_live = '0;
        fifo_in_live = 4'b0100; fifo_short_live = 4'b0010;
        rd(2);
        chk("R2 fifo layout", bus_rdata, 32'h0004_0008);
        fifo_in_live = '0; fifo_short_live = '0;
        // R4
        aux_evt = 4'b1001;
        cyc();
        aux_evt = '0;
        rd(6);
        chk("R4 aux sticky", bus_rdata, 32'h9);
        wr(6, 32'hF);
        // R9: enable gating of the OTG source
        wr(13, 32'hD);
        otg_evt = 13'h0040;
        cyc();
        otg_evt = '0;
        rd(12);
        chk("R9 enable blocks", {31'b0, irq_o}, 32'h0);
        wr(11, 32'h40);
        rd(12);
        chk("R9 enabled line", {31'b0, irq_o}, 32'h1);
        chk("R9 global bit", bus_rdata, 32'h2);
        wr(10, 32'h40);
        rd(10);
        chk("R9 cleared", bus_rdata, 32'h0);
        rd(15);
        chk("R13 unmapped", bus_rdata, 32'h0);
        // R10: active-low polarity with host source
        wr(13, 32'h0);
        host_live = 1'b1;
        rd(12);
        chk("R10 active low", {31'b0, irq_o}, 32'h0);
        chk("R10 host status", bus_rdata, 32'h4);
        host_live = 1'b0;

        for (int i = 0; i < 4000; i++) begin
            cx_live         = 5'($urandom);
            cx_abort        = ($urandom % 8) == 0;
            fifo_out_live   = 4'($urandom & $urandom);
            fifo_short_live = 4'($urandom & $urandom);
            fifo_in_live    = 4'($urandom & $urandom);
            bus_evt         = 9'($urandom & $urandom & $urandom);
            idle_live       = ($urandom % 4) == 0;
            vbus_wake_live  = ($urandom % 4) == 0;
            aux_evt         = 4'($urandom & $urandom & $urandom);
            otg_evt         = 13'($urandom & $urandom & $urandom);
            host_live       = ($urandom % 8) == 0;
            bus_we          = ($urandom % 3) == 0;
            bus_addr        = 4'($urandom);
            bus_wdata       = $urandom;
            cyc();
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule